// File: doc/BRIEF.md
# MDIO Management Bus Master

This block is a memory-mapped master for the two-wire PHY management bus. Software programs it through four 32-bit word registers on a simple write-strobe bus. Reads are combinational on the word index. Each bus action is launched as a side effect of a register write. The master then serialises one 64-slot frame on the data line, and it produces the management clock from the system clock through a programmable divider. Both the short-form (Clause 22) and the extended (Clause 45) frame formats are supported. Which one is used depends on one configuration bit.

The register bus has no stream interface and no handshake. A write either takes effect in the cycle it is strobed or is dropped. The data line is split into an input, an output and an output enable, and the board-level tri-state buffer sits outside the block. A line that no PHY drives is expected to read as 1 through the external pull-up.

Register map, with word index in `reg_idx`:
- 0 configuration/status: bit 0 frame busy (read-only), bit 1 read error (read-only), bit 2 extended-format enable, bit 3 sample read bits on the falling clock edge, bits 31:16 clock divider.
- 1 control: bits 4:0 device address (the register number in short form), bits 9:5 port address, bit 15 read trigger (reads back 0).
- 2 data: bits 15:0 data, bit 31 data busy (read-only).
- 3 address: bits 15:0 extended register address.

Top module: `mdio_master`

## Requirements
- R1: After reset, the configuration/status word reads 0x0102_0000: divider 258, short format, rising-edge sampling, not busy, no error. The data word reads 0, and `mdc` and `mdio_oe` are low.
- R2: A short-format frame is laid out as follows, each field MSB first, one bit per clock period. It opens with 32 ones. Then come start 01 and opcode 10 for a read or 01 for a write, the 5-bit port address, the 5-bit register number taken from control bits 4:0, a 2-bit turnaround and 16 data bits.
- R3: An extended-format frame has the same layout with start 00. Its opcode is 00 for an address frame, 01 for a write and 11 for a read.
- R4: In extended format, a write to the address word launches an address frame that carries the 16-bit value, with the ports and devices held in control. In short format the value is only stored and no frame starts.
- R5: A write to the data word launches a write frame to the port and device held in control. The master drives the turnaround as 1 then 0.
- R6: A write to control with bit 15 set launches a read frame with the written port and device. The master releases the line (`mdio_oe` low) from the first turnaround slot to the end of the frame. The 16 sampled bits land in the data word.
- R7: If the second turnaround slot is sampled high, status bit 1 is set and the data word becomes 0xFFFF. The flag clears when the next frame is launched.
- R8: Status bit 0 is high from the cycle after a launch until the frame has finished. Data bit 31 is high over the same span for read and write frames only, and never for address frames.
- R9: While status bit 0 is high, writes to every register are ignored.
- R10: `mdc` is low whenever no frame runs. While a frame runs, each half-period lasts as many system clocks as the divider field, and a divider of 0 acts as 1.
- R11: With configuration bit 3 set, read bits are sampled at the falling `mdc` edge that ends each bit slot instead of the rising edge. Output bits change on falling edges in both modes, and the data read back is the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 2 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_idx` |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Sampled data line |
| mdio_o | output | 1 | Driven data line value |
| mdio_oe | output | 1 | Data line output enable |

## Verification
On every cycle, the embedded assertions check four things. The management clock is idle low outside a frame. The line is released only during read frames. Register state holds still under writes made while busy. An errored read leaves 0xFFFF in the data word. Only the bench's scenarios can show that each complete 64-slot frame carries the right start, opcode, address and data bits in both formats. They also show that a responding or absent PHY yields the right data and error flag, that a short-format address write launches nothing, and that the measured half-period follows the divider.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_W   = 32;
  localparam int PA_W    = 5;
  localparam int DA_W    = 5;
  localparam int DW      = 16;
  localparam int DIV_W   = 16;
  localparam int FRAME_W = PRE_W + 2 + 2 + PA_W + DA_W + 2 + DW;
  localparam int TA0     = FRAME_W - DW - 2;
  localparam logic [1:0] IDX_CFG = 2'd0;
  localparam logic [1:0] IDX_CTL = 2'd1;
  localparam logic [1:0] IDX_DAT = 2'd2;
  localparam logic [1:0] IDX_ADR = 2'd3;
  typedef enum logic [1:0] {K_ADDR = 2'd0, K_WRITE = 2'd1, K_READ = 2'd2} op_kind_e;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIVW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DIVW-1:0] div,
  output logic            mdc,
  output logic            rise,
  output logic            fall
);
  logic [DIVW-1:0] cnt;
  logic [DIVW-1:0] lim;
  logic            term;

  always_comb begin
    lim  = (div == '0) ? DIVW'(1) : div;
    term = (cnt == lim - DIVW'(1));
    rise = run && term && !mdc;
    fall = run && term && mdc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (term) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + DIVW'(1);
    end
  end
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng #(
  parameter int FW  = 64,
  parameter int DW  = 16,
  parameter int TA0 = 46
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [FW-1:0] frame,
  input  logic          is_read,
  input  logic          neg_sample,
  input  logic          rise,
  input  logic          fall,
  input  logic          mdio_i,
  output logic          running,
  output logic          done,
  output logic          mdio_o,
  output logic          mdio_oe,
  output logic [DW-1:0] rd_word,
  output logic          rd_err
);
  localparam int SW = $clog2(FW);
  localparam logic [SW-1:0] LAST  = SW'(FW - 1);
  localparam logic [SW-1:0] TA_LO = SW'(TA0);
  localparam logic [SW-1:0] TA_HI = SW'(TA0 + 1);
  localparam logic [SW-1:0] DAT0  = SW'(TA0 + 2);

  logic [SW-1:0] slot;
  logic [SW-1:0] slot_nx;
  logic [FW-1:0] shreg;
  logic          rd_is;
  logic          samp;

  always_comb begin
    slot_nx = slot + SW'(1);
    samp    = running && rd_is && (neg_sample ? fall : rise);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      done    <= 1'b0;
      slot    <= '0;
      shreg   <= '0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      rd_is   <= 1'b0;
      rd_err  <= 1'b0;
      rd_word <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        running <= 1'b1;
        slot    <= '0;
        shreg   <= frame;
        mdio_o  <= frame[FW-1];
        mdio_oe <= 1'b1;
        rd_is   <= is_read;
        rd_err  <= 1'b0;
      end else if (running) begin
        if (samp && slot == TA_HI) rd_err <= mdio_i;
        if (samp && slot >= DAT0) rd_word <= {rd_word[DW-2:0], mdio_i};
        if (fall) begin
          if (slot == LAST) begin
            running <= 1'b0;
            done    <= 1'b1;
            mdio_oe <= 1'b0;
            mdio_o  <= 1'b1;
          end else begin
            slot    <= slot_nx;
            shreg   <= {shreg[FW-2:0], 1'b0};
            mdio_o  <= shreg[FW-2];
            mdio_oe <= !(rd_is && slot_nx >= TA_LO);
          end
        end
      end
    end
  end

  assert_release_only_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !mdio_oe) |-> rd_is);
  assert_end_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (running && fall && slot == LAST) |=> (!running && done));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_RST = 258
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_idx,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);
  logic [DIV_W-1:0] cfg_div;
  logic             cfg_enc, cfg_neg;
  logic [PA_W-1:0]  ctl_port;
  logic [DA_W-1:0]  ctl_dev;
  logic [DW-1:0]    data_q, addr_q;
  op_kind_e         kind_q, kind_s;
  logic             wr_ok, start_adr, start_wr, start_rd, start_any;
  logic [PA_W-1:0]  port_s;
  logic [DA_W-1:0]  dev_s;
  logic [1:0]       st_s, op_s;
  logic [DW-1:0]    pay_s;
  logic [FRAME_W-1:0] frame_s;
  logic             eng_run, eng_done, eng_err, busy, rise, fall;
  logic [DW-1:0]    rd_word;

  always_comb begin
    busy      = eng_run || eng_done;
    wr_ok     = reg_wr && !busy;
    start_adr = wr_ok && reg_idx == IDX_ADR && cfg_enc;
    start_wr  = wr_ok && reg_idx == IDX_DAT;
    start_rd  = wr_ok && reg_idx == IDX_CTL && reg_wdata[15];
    start_any = start_adr || start_wr || start_rd;
    kind_s    = start_rd ? K_READ : (start_wr ? K_WRITE : K_ADDR);
    port_s    = start_rd ? reg_wdata[9:5] : ctl_port;
    dev_s     = start_rd ? reg_wdata[4:0] : ctl_dev;
    st_s      = cfg_enc ? 2'b00 : 2'b01;
    case (kind_s)
      K_READ:  op_s = cfg_enc ? 2'b11 : 2'b10;
      K_WRITE: op_s = 2'b01;
      default: op_s = 2'b00;
    endcase
    pay_s   = start_rd ? '1 : reg_wdata[DW-1:0];
    frame_s = {{PRE_W{1'b1}}, st_s, op_s, port_s, dev_s, 2'b10, pay_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_div  <= DIV_W'(DIV_RST);
      cfg_enc  <= 1'b0;
      cfg_neg  <= 1'b0;
      ctl_port <= '0;
      ctl_dev  <= '0;
      data_q   <= '0;
      addr_q   <= '0;
      kind_q   <= K_ADDR;
    end else begin
      if (wr_ok) begin
        case (reg_idx)
          IDX_CFG: begin
            cfg_div <= reg_wdata[31:16];
            cfg_neg <= reg_wdata[3];
            cfg_enc <= reg_wdata[2];
          end
          IDX_CTL: begin
            ctl_port <= reg_wdata[9:5];
            ctl_dev  <= reg_wdata[4:0];
          end
          IDX_DAT: data_q <= reg_wdata[DW-1:0];
          default: addr_q <= reg_wdata[DW-1:0];
        endcase
      end
      if (start_any) kind_q <= kind_s;
      if (eng_done && kind_q == K_READ) data_q <= eng_err ? '1 : rd_word;
    end
  end

  always_comb begin
    case (reg_idx)
      IDX_CFG: reg_rdata = {cfg_div, 12'b0, cfg_neg, cfg_enc, eng_err, busy};
      IDX_CTL: reg_rdata = {22'b0, ctl_port, ctl_dev};
      IDX_DAT: reg_rdata = {busy && kind_q != K_ADDR, 15'b0, data_q};
      default: reg_rdata = {16'b0, addr_q};
    endcase
  end

  mdio_mdc_gen #(.DIVW(DIV_W)) u_mdc (
    .clk(clk), .rst_n(rst_n), .run(eng_run), .div(cfg_div),
    .mdc(mdc), .rise(rise), .fall(fall)
  );

  mdio_frame_eng #(.FW(FRAME_W), .DW(DW), .TA0(TA0)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start_any), .frame(frame_s),
    .is_read(start_rd), .neg_sample(cfg_neg), .rise(rise), .fall(fall),
    .mdio_i(mdio_i), .running(eng_run), .done(eng_done), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .rd_word(rd_word), .rd_err(eng_err)
  );

  assert_idle_mdc_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
  assert_stop_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eng_run) |-> !mdc);
  assert_busy_ignores_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr) |=> ($stable(cfg_div) && $stable(ctl_port) && $stable(addr_q)));
  assert_err_all_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && kind_q == K_READ && eng_err) |=> (data_q == 16'hFFFF));
  assert_launch_by_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_run) |-> $past(reg_wr));
endmodule

// File: tb/sim_mdio_master.sv
`timescale 1ns/1ps
module sim_mdio_master;
  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [1:0] reg_idx = 2'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mdc, mdio_o, mdio_oe, line;
  logic phy_drv = 1'b0, phy_bit = 1'b1, phy_present = 1'b0, mdc_prev = 1'b0;
  logic [15:0] phy_data = '0;
  logic [63:0] cap = '0;
  int rises = 0, checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  always #10 clk = ~clk;
  assign line = mdio_oe ? mdio_o : (phy_drv ? phy_bit : 1'b1);

  mdio_master u0 (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc), .mdio_i(line),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe));

  // PHY responder: captures every slot, answers reads after slot 46
  always @(negedge clk) begin
    if (mdc && !mdc_prev) begin
      cap = {cap[62:0], line};
      rises++;
    end
    if (!mdc && mdc_prev) begin
      if (rises == 47 && phy_present && (cap[14:11] == 4'b0110 || cap[14:11] == 4'b0011)) begin
        phy_drv = 1'b1; phy_bit = 1'b0;
      end else if (rises >= 48 && rises <= 63 && phy_drv) begin
        phy_bit = phy_data[63 - rises];
      end else begin
        phy_drv = 1'b0;
      end
    end
    mdc_prev = mdc;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired act=%0d exp<=150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] idx, logic [31:0] val);
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = idx; reg_wdata = val;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] idx, output logic [31:0] val);
    reg_idx = idx;
    #1 val = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    int n = 0;
    rd(2'd0, s);
    while (s[0] && n < 40000) begin
      @(negedge clk); n++; rd(2'd0, s);
    end
    if (n >= 40000) chk("R8 frame never ended", 64'd1, 64'd0);
  endtask

  function automatic logic [63:0] exp_frame(bit enc, logic [1:0] kind,
      logic [4:0] p, logic [4:0] d, logic [15:0] v, bit phy);
    logic [1:0] op, ta;
    logic [15:0] dat;
    bit miss;
    miss = (kind == 2'd2) && !phy;
    op  = (kind == 2'd0) ? 2'b00 : (kind == 2'd1) ? 2'b01 : (enc ? 2'b11 : 2'b10);
    ta  = miss ? 2'b11 : 2'b10;
    dat = miss ? 16'hFFFF : v;
    return {32'hFFFF_FFFF, (enc ? 2'b00 : 2'b01), op, p, d, ta, dat};
  endfunction

  // {neg, enc, kind(0 addr,1 write,2 read), phy, port, dev, 0, value}
  localparam logic [31:0] VEC [8] = '{
    {1'b0, 1'b0, 2'd1, 1'b0, 5'd3,  5'h11, 1'b0, 16'hA5C3},
    {1'b0, 1'b0, 2'd2, 1'b1, 5'd1,  5'd2,  1'b0, 16'h1234},
    {1'b0, 1'b1, 2'd0, 1'b0, 5'd5,  5'd1,  1'b0, 16'h00C8},
    {1'b0, 1'b1, 2'd1, 1'b0, 5'd5,  5'd1,  1'b0, 16'hBEEF},
    {1'b0, 1'b1, 2'd2, 1'b1, 5'h1F, 5'h1E, 1'b0, 16'h8001},
    {1'b0, 1'b0, 2'd2, 1'b0, 5'd9,  5'd4,  1'b0, 16'h0000},
    {1'b1, 1'b1, 2'd2, 1'b1, 5'd2,  5'd7,  1'b0, 16'h5A0F},
    {1'b1, 1'b0, 2'd2, 1'b1, 5'd6,  5'd3,  1'b0, 16'h7E81}
  };

  initial begin
    logic [31:0] r;
    int n;
    #35 rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, r); chk("R1 cfg reset", 64'(r), 64'h0102_0000);
    rd(2'd2, r); chk("R1 data reset", 64'(r), 64'h0);
    chk("R1 mdc/oe reset", {62'b0, mdc, mdio_oe}, 64'h0);

    for (int i = 0; i < 8; i++) begin
      logic [31:0] v;
      bit neg, enc, phy;
      logic [1:0] kind;
      logic [15:0] expd;
      v = VEC[i];
      neg = v[31]; enc = v[30]; kind = v[29:28]; phy = v[27];
      wr(2'd0, {16'd2, 12'b0, neg, enc, 2'b00});
      phy_present = phy; phy_data = v[15:0];
      rises = 0; cap = '0;
      if (kind == 2'd2) wr(2'd1, {16'b0, 1'b1, 5'b0, v[26:22], v[21:17]});
      else begin
        wr(2'd1, {22'b0, v[26:22], v[21:17]});
        wr(kind == 2'd0 ? 2'd3 : 2'd2, {16'b0, v[15:0]});
      end
      rd(2'd0, r);
      chk($sformatf("R8 busy+R7 cleared vec%0d", i), {62'b0, r[1:0]}, 64'b01);
      rd(2'd2, r);
      chk($sformatf("R8 data busy vec%0d", i), 64'(r[31]), 64'(kind != 2'd0));
      wait_idle();
      chk($sformatf("R2 R3 R5 R6 frame vec%0d", i), cap,
          exp_frame(enc, kind, v[26:22], v[21:17], v[15:0], phy));
      rd(2'd0, r);
      chk($sformatf("R7 err flag vec%0d", i), 64'(r[1]), 64'(kind == 2'd2 && !phy));
      expd = (kind == 2'd2 && !phy) ? 16'hFFFF : v[15:0];
      rd(2'd2, r);
      if (kind != 2'd0) chk($sformatf("R6 R11 data word vec%0d", i), 64'(r), 64'(expd));
    end

    // R4: short-format address write stores only
    wr(2'd0, {16'd2, 16'h0000});
    wr(2'd3, 32'h0000_4321);
    repeat (10) @(negedge clk);
    rd(2'd0, r); chk("R4 no frame in short format", 64'(r[0]), 64'd0);
    rd(2'd3, r); chk("R4 address stored", 64'(r), 64'h4321);
    chk("R4 no mdc activity", 64'(mdc), 64'd0);

    // R10: half period follows divider, 0 acts as 1
    for (int k = 0; k < 2; k++) begin
      int dv;
      dv = (k == 0) ? 3 : 0;
      wr(2'd0, {16'(dv), 16'h0000});
      wr(2'd2, 32'h0000_0F0F);
      n = 0;
      while (!mdc && n < 100) begin @(negedge clk); n++; end
      n = 0;
      while (mdc && n < 100) begin n++; @(negedge clk); end
      chk($sformatf("R10 half period div=%0d", dv), 64'(n), 64'((dv == 0) ? 1 : dv));
      wait_idle();
      chk("R10 mdc idle low", 64'(mdc), 64'd0);
    end

    // R9: writes while busy are dropped
    wr(2'd0, {16'd2, 16'h0000});
    phy_present = 1'b1; phy_data = 16'h3C3C; rises = 0;
    wr(2'd1, {16'b0, 1'b1, 5'b0, 5'd4, 5'd8});
    wr(2'd2, 32'h0000_1111);
    wr(2'd0, {16'd9, 16'h0004});
    wr(2'd1, {16'b0, 1'b1, 5'b0, 5'd7, 5'd7});
    wr(2'd3, 32'h0000_2222);
    wait_idle();
    rd(2'd2, r); chk("R9 data kept read result", 64'(r), 64'h3C3C);
    rd(2'd0, r); chk("R9 cfg unchanged", 64'(r), 64'h0002_0000);
    rd(2'd1, r); chk("R9 ctrl unchanged", 64'(r), {54'b0, 5'd4, 5'd8});
    rd(2'd3, r); chk("R9 addr unchanged", 64'(r), 64'h4321);
    repeat (40) @(negedge clk);
    rd(2'd0, r); chk("R9 no second frame", 64'(r[0]), 64'd0);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule